// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Byte

This block is the digital side of a successive-approximation converter. It holds one byte that software writes and reads (a completion flag, an interrupt enable, a continuous-run enable and a five-bit channel code), decides when each conversion begins, and reports when one has finished. Toward the analog macro it drives the channel code, a one-cycle start pulse and a power enable. It receives a one-cycle done strobe and the result word in return.

Conversions are started by a write to the byte (software start) or by a rising edge on a trigger pin (hardware start). They run once or repeat back to back. An optional window comparator outside the block can require its own true result before a finished conversion is flagged. Channel code 31 switches the converter off. Writing that code while conversions repeat stops them at once, and no further conversion follows.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status byte reads 0x1F, `chan_sel` is 31, and `conv_pwr`, `conv_start` and `irq` are low.
- R2: Byte layout: bit 7 completion flag (read-only; written value ignored), bit 6 interrupt enable, bit 5 continuous enable, bits 4:0 channel code. A written code appears on `chan_sel` in the cycle after the write. Codes 0–27 pick external inputs, 28 is reserved, 29 picks the high reference and 30 the low reference. All codes other than 31 are converted in the same way.
- R3: With `hw_sel` low, a write with a code other than 31 gives a one-cycle `conv_start` pulse with `conv_pwr` high in the cycle after the write. In single mode, `conv_pwr` falls on the edge where the completion is accepted, and no further start follows.
- R4: With `cmp_en` low, every accepted completion sets the flag. With `cmp_en` high, the flag is set only if `cmp_true` is high together with `conv_done`. `result_q` loads `conv_result` only when the flag is set.
- R5: A write or an `rd_lo` pulse clears the flag in the following cycle. When a completion and an `rd_lo` pulse fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly while the flag and the interrupt enable are both set, and it changes on the same edge as the flag.
- R7: In continuous mode, a new `conv_start` pulse follows in the cycle after each accepted completion, and `conv_pwr` stays high.
- R8: With `hw_sel` high, a write starts nothing. A rising edge of `hw_trig` (low at one clock edge, high at the next) starts a conversion in the following cycle. In continuous mode the chain then repeats. Rising edges seen while a conversion runs are ignored.
- R9: Writing code 31 drops `conv_pwr` in the next cycle. No later `conv_start` follows, and a pending conversion is never flagged.
- R10: A write while a conversion runs aborts it and starts a new one (per R3/R8) under the new settings. The aborted conversion is never flagged, and a `conv_done` in the same cycle as the write is discarded.
- R11: A `conv_done` while no conversion runs is ignored (flag and `result_q` unchanged). `hw_trig` has no effect while `hw_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Current status byte |
| rd_lo | input | 1 | Pulse marking a read of the result low byte |
| hw_sel | input | 1 | 1 = hardware trigger starts conversions |
| hw_trig | input | 1 | Hardware trigger level (rising edge acts) |
| cmp_en | input | 1 | Compare gating of the flag enabled |
| cmp_true | input | 1 | Compare outcome, valid with conv_done |
| chan_sel | output | 5 | Channel code to the converter |
| conv_start | output | 1 | One-cycle start pulse |
| conv_pwr | output | 1 | Converter power enable |
| conv_done | input | 1 | One-cycle conversion-finished strobe |
| conv_result | input | 12 | Converter result word |
| result_q | output | 12 | Result of the last flagged conversion |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Each output is registered, so every response appears on the first edge that samples its cause. Start pulse, power change and channel code follow a write edge by one cycle. A trigger start follows the first edge where the trigger is seen high. The flag, `irq`, `result_q` and a continuous restart all change on the edge that samples `conv_done`. With the bench's converter model answering five cycles after it sees a start, the flag rises seven cycles after the cycle in which the write is driven. The driver records every expectation with the exact cycle in which it falls due, and the monitor compares only in that cycle, at the falling edge. Early and late responses therefore both fail, including the coinciding done/clear and abort cases.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int CH_W = 5;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;

  // status byte, MSB first; the flag position is decoded by software
  typedef struct packed {
    logic            flag;
    logic            ie;
    logic            cont;
    logic [CH_W-1:0] ch;
  } ctl_byte_t;

  localparam int BYTE_W = $bits(ctl_byte_t);
endpackage

// File: rtl/adc_ctl_edge.sv
module adc_ctl_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
#(
  parameter int CW = CH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_ch,
  input  logic          hw_sel,
  input  logic          trig_rise,
  input  logic          conv_done,
  input  logic          cont_q,
  input  logic [CW-1:0] ch_q,
  output logic          conv_start,
  output logic          conv_pwr,
  output logic          done_evt
);
  localparam logic [CW-1:0] CH_OFF = '1;

  seq_state_t state_q, state_n;
  logic       start_n, pwr_n;

  always_comb begin
    state_n  = state_q;
    start_n  = 1'b0;
    pwr_n    = conv_pwr;
    done_evt = 1'b0;
    if (wr_en) begin
      // a write always aborts; it restarts only under software start
      if (wr_ch == CH_OFF || hw_sel) begin
        state_n = SEQ_IDLE;
        pwr_n   = 1'b0;
      end else begin
        state_n = SEQ_BUSY;
        start_n = 1'b1;
        pwr_n   = 1'b1;
      end
    end else if (state_q == SEQ_BUSY) begin
      if (conv_done) begin
        done_evt = 1'b1;
        if (cont_q) begin
          start_n = 1'b1;
        end else begin
          state_n = SEQ_IDLE;
          pwr_n   = 1'b0;
        end
      end
    end else if (hw_sel && trig_rise && ch_q != CH_OFF) begin
      state_n = SEQ_BUSY;
      start_n = 1'b1;
      pwr_n   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      conv_start <= 1'b0;
      conv_pwr   <= 1'b0;
    end else begin
      state_q    <= state_n;
      conv_start <= start_n;
      conv_pwr   <= pwr_n;
    end
  end
endmodule

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_ctl_pkg::*;
#(
  parameter int RW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_lo,
  input  logic              done_evt,
  input  logic              cmp_en,
  input  logic              cmp_true,
  input  logic [RW-1:0]     conv_result,
  output ctl_byte_t         ctl_q,
  output logic              irq,
  output logic [RW-1:0]     result_q
);
  ctl_byte_t wr_byte;
  logic      flag_set, flag_n, ie_n;

  assign wr_byte  = ctl_byte_t'(wr_data);
  assign flag_set = done_evt && (!cmp_en || cmp_true);
  // set has priority over either clear source
  assign flag_n   = flag_set ? 1'b1 : ((wr_en || rd_lo) ? 1'b0 : ctl_q.flag);
  assign ie_n     = wr_en ? wr_byte.ie : ctl_q.ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '{flag: 1'b0, ie: 1'b0, cont: 1'b0, ch: '1};
      irq      <= 1'b0;
      result_q <= '0;
    end else begin
      ctl_q.flag <= flag_n;
      if (wr_en) begin
        ctl_q.ie   <= wr_byte.ie;
        ctl_q.cont <= wr_byte.cont;
        ctl_q.ch   <= wr_byte.ch;
      end
      irq <= flag_n & ie_n;
      if (flag_set) result_q <= conv_result;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              rd_lo,
  input  logic              hw_sel,
  input  logic              hw_trig,
  input  logic              cmp_en,
  input  logic              cmp_true,
  output logic [CH_W-1:0]   chan_sel,
  output logic              conv_start,
  output logic              conv_pwr,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [RES_W-1:0]  result_q,
  output logic              irq
);
  ctl_byte_t ctl_q;
  ctl_byte_t wr_byte;
  logic      trig_rise;
  logic      done_evt;

  assign wr_byte = ctl_byte_t'(wr_data);

  adc_ctl_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (hw_trig),
    .rise  (trig_rise)
  );

  adc_ctl_seq #(.CW(CH_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_ch      (wr_byte.ch),
    .hw_sel     (hw_sel),
    .trig_rise  (trig_rise),
    .conv_done  (conv_done),
    .cont_q     (ctl_q.cont),
    .ch_q       (ctl_q.ch),
    .conv_start (conv_start),
    .conv_pwr   (conv_pwr),
    .done_evt   (done_evt)
  );

  adc_ctl_reg #(.RW(RES_W)) u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_lo       (rd_lo),
    .done_evt    (done_evt),
    .cmp_en      (cmp_en),
    .cmp_true    (cmp_true),
    .conv_result (conv_result),
    .ctl_q       (ctl_q),
    .irq         (irq),
    .result_q    (result_q)
  );

  assign rd_data  = ctl_q;
  assign chan_sel = ctl_q.ch;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          conv_done,
  input logic          conv_start,
  input logic          conv_pwr,
  input logic [CW-1:0] chan_sel,
  input logic [7:0]    rd_data,
  input logic          irq
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h1F && !conv_pwr && !conv_start && !irq));

  // R6
  a_r6_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
    irq == (rd_data[7] && rd_data[6]));

  // R5
  a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rd_data[7]);

  // R9
  a_r9_off_code_idle: assert property (@(posedge clk) disable iff (rst)
    (chan_sel == '1) |-> (!conv_pwr && !conv_start));

  // R3
  a_r3_single_power_drop: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_pwr && !wr_en && !rd_data[5]) |=> !conv_pwr);

  // R7
  a_r7_start_powered: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_pwr);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CW(adc_ctl_pkg::CH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .conv_done  (conv_done),
  .conv_start (conv_start),
  .conv_pwr   (conv_pwr),
  .chan_sel   (chan_sel),
  .rd_data    (rd_data),
  .irq        (irq)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int RES_W = 12;
  localparam int DLY   = 5;
  localparam int K_RD = 0, K_IRQ = 1, K_PWR = 2, K_START = 3, K_RES = 4, K_CH = 5;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, rd_lo, hw_sel, hw_trig, cmp_en, cmp_true, stray_done;
  logic [7:0] wr_data, rd_data;
  logic [4:0] chan_sel;
  logic conv_start, conv_pwr, conv_done, irq;
  logic [RES_W-1:0] conv_result, result_q;
  logic [3:0] mcnt;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int due_q[$];
  int kind_q[$];
  int val_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl #(.RES_W(RES_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rd_lo(rd_lo), .hw_sel(hw_sel), .hw_trig(hw_trig), .cmp_en(cmp_en),
    .cmp_true(cmp_true), .chan_sel(chan_sel), .conv_start(conv_start),
    .conv_pwr(conv_pwr), .conv_done(conv_done), .conv_result(conv_result),
    .result_q(result_q), .irq(irq)
  );

  // converter model: done strobe DLY cycles after it samples a start
  always @(posedge clk) begin
    if (rst || !conv_pwr) mcnt <= 4'd0;
    else if (conv_start)  mcnt <= 4'(DLY);
    else if (mcnt != 0)   mcnt <= mcnt - 4'd1;
  end
  assign conv_done = (mcnt == 4'd1) || stray_done;

  function automatic int actual(int k);
    case (k)
      K_RD:    return int'(rd_data);
      K_IRQ:   return int'(irq);
      K_PWR:   return int'(conv_pwr);
      K_START: return int'(conv_start);
      K_RES:   return int'(result_q);
      default: return int'(chan_sel);
    endcase
  endfunction

  // scoreboard monitor: compares each item in the cycle it falls due
  always @(negedge clk) begin
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        n_chk++;
        if (actual(kind_q[i]) != val_q[i]) begin
          n_fail++;
          $display("FAIL %s kind %0d cycle %0d: actual 0x%0h expected 0x%0h",
                   tag_q[i], kind_q[i], cyc, actual(kind_q[i]), val_q[i]);
        end
        due_q.delete(i); kind_q.delete(i); val_q.delete(i); tag_q.delete(i);
      end
    end
  end

  task automatic ex(int d, int k, int v, string tag);
    due_q.push_back(cyc + d); kind_q.push_back(k);
    val_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdlo();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual run still going, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; rd_lo = 1'b0; hw_sel = 1'b0;
    hw_trig = 1'b0; cmp_en = 1'b0; cmp_true = 1'b0; stray_done = 1'b0;
    conv_result = 12'h000;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    ex(1, K_RD, 8'h1F, "R1"); ex(1, K_PWR, 0, "R1"); ex(1, K_IRQ, 0, "R1");
    ex(1, K_START, 0, "R1"); ex(1, K_CH, 5'h1F, "R1");
    idle(3);

    // R2 R3 R6 software single conversion
    conv_result = 12'hABC;
    ex(1, K_CH, 5, "R2"); ex(1, K_START, 1, "R3"); ex(1, K_PWR, 1, "R3");
    ex(2, K_START, 0, "R3"); ex(6, K_RD, 8'h45, "R3"); ex(6, K_PWR, 1, "R3");
    ex(6, K_IRQ, 0, "R6"); ex(7, K_RD, 8'hC5, "R4"); ex(7, K_IRQ, 1, "R6");
    ex(7, K_PWR, 0, "R3"); ex(7, K_RES, 12'hABC, "R4"); ex(12, K_START, 0, "R3");
    wr(8'h45);
    idle(12);

    // R5 clear by result read
    ex(1, K_RD, 8'h45, "R5"); ex(1, K_IRQ, 0, "R6");
    rdlo();
    idle(3);

    // R2 flag bit read-only, R9 off code in single mode
    ex(1, K_RD, 8'h1F, "R2"); ex(1, K_PWR, 0, "R9"); ex(1, K_START, 0, "R9");
    ex(1, K_CH, 5'h1F, "R9"); ex(8, K_RD, 8'h1F, "R9"); ex(8, K_START, 0, "R9");
    wr(8'h9F);
    idle(9);

    // R4 compare gating; reserved code 28 converts like any other (R2)
    cmp_en = 1'b1; cmp_true = 1'b0;
    ex(1, K_CH, 5'h1C, "R2"); ex(1, K_START, 1, "R2");
    ex(7, K_RD, 8'h1C, "R4"); ex(7, K_PWR, 0, "R4"); ex(7, K_RES, 12'hABC, "R4");
    wr(8'h1C);
    idle(8);
    conv_result = 12'h123; cmp_true = 1'b1;
    ex(7, K_RD, 8'h83, "R4"); ex(7, K_RES, 12'h123, "R4");
    wr(8'h03);
    idle(8);
    cmp_en = 1'b0; cmp_true = 1'b0;

    // R5 write clears; set wins over a coinciding read
    ex(1, K_RD, 8'h03, "R5"); ex(7, K_RD, 8'h83, "R5"); ex(8, K_RD, 8'h83, "R5");
    wr(8'h03);
    idle(5);
    rdlo();
    idle(3);

    // R7 continuous software conversions, then R9 stop with code 31
    conv_result = 12'h055;
    ex(1, K_START, 1, "R7"); ex(2, K_START, 0, "R7"); ex(7, K_START, 1, "R7");
    ex(7, K_RD, 8'hA7, "R7"); ex(7, K_PWR, 1, "R7"); ex(13, K_START, 1, "R7");
    ex(13, K_PWR, 1, "R7");
    wr(8'h27);
    idle(14);
    ex(1, K_PWR, 0, "R9"); ex(1, K_START, 0, "R9"); ex(1, K_RD, 8'h3F, "R9");
    ex(8, K_RD, 8'h3F, "R9"); ex(8, K_START, 0, "R9"); ex(8, K_PWR, 0, "R9");
    wr(8'h3F);
    idle(10);

    // R10 abort by a write during a conversion
    ex(1, K_START, 1, "R10"); ex(5, K_START, 1, "R10"); ex(7, K_RD, 8'h42, "R10");
    ex(7, K_PWR, 1, "R10"); ex(10, K_RD, 8'h42, "R10"); ex(11, K_RD, 8'hC2, "R10");
    ex(11, K_IRQ, 1, "R10");
    wr(8'h02);
    idle(3);
    wr(8'h42);
    idle(10);
    rdlo();
    idle(2);

    // R8 hardware single: write starts nothing, busy-time edge ignored
    hw_sel = 1'b1;
    ex(1, K_START, 0, "R8"); ex(1, K_PWR, 0, "R8"); ex(3, K_START, 0, "R8");
    ex(3, K_RD, 8'h04, "R8");
    wr(8'h04);
    idle(3);
    ex(1, K_START, 1, "R8"); ex(2, K_START, 0, "R8"); ex(5, K_START, 0, "R8");
    ex(6, K_START, 0, "R8"); ex(6, K_RD, 8'h04, "R8"); ex(7, K_RD, 8'h84, "R8");
    ex(7, K_PWR, 0, "R8"); ex(10, K_START, 0, "R8"); ex(10, K_PWR, 0, "R8");
    hw_trig = 1'b1;
    idle(2);
    hw_trig = 1'b0;
    idle(2);
    hw_trig = 1'b1;
    idle(1);
    hw_trig = 1'b0;
    idle(8);

    // R8 hardware continuous chain
    ex(1, K_START, 0, "R8"); ex(1, K_RD, 8'h24, "R8");
    wr(8'h24);
    idle(2);
    ex(1, K_START, 1, "R8"); ex(7, K_START, 1, "R8"); ex(7, K_RD, 8'hA4, "R8");
    ex(7, K_PWR, 1, "R8");
    hw_trig = 1'b1;
    idle(1);
    hw_trig = 1'b0;
    idle(8);
    ex(1, K_PWR, 0, "R9"); ex(4, K_START, 0, "R9");
    wr(8'h1F);
    idle(5);
    hw_sel = 1'b0;

    // R11 trigger ignored under software start
    ex(1, K_START, 1, "R3"); ex(7, K_RD, 8'h84, "R4");
    wr(8'h04);
    idle(8);
    ex(1, K_START, 0, "R11"); ex(1, K_PWR, 0, "R11"); ex(2, K_START, 0, "R11");
    hw_trig = 1'b1;
    idle(1);
    hw_trig = 1'b0;
    idle(4);

    // R11 stray done while idle
    ex(1, K_RD, 8'h04, "R5");
    rdlo();
    idle(1);
    conv_result = 12'h3C3;
    ex(1, K_RD, 8'h04, "R11"); ex(1, K_RES, 12'h055, "R11");
    ex(1, K_PWR, 0, "R11"); ex(1, K_START, 0, "R11");
    stray_done = 1'b1;
    idle(1);
    stray_done = 1'b0;
    idle(3);

    if (due_q.size() != 0) begin
      n_fail += due_q.size();
      $display("FAIL scoreboard: actual %0d items left, expected 0", due_q.size());
    end
    summary();
    $finish;
  end
endmodule